// File: doc/BRIEF.md
# Staged Display Enable Sequencer

This block powers a display pipeline up and down in three ordered stages: the pixel clock, the sync timing, and the display data. A host starts stages with a write-to-set command and stops them with a write-to-clear command. It polls a per-stage status vector until each stage is confirmed. The status bits also serve as the stage enables for the timing generator.

The sync and display stages take effect only at a frame boundary, which the timing generator signals. The pixel clock stage takes effect on the next cycle. Any request that would break the stage order is refused, and status does not change.

The block also produces a single-cycle pixel clock enable from the system clock through a programmable divider. A select bit picks a source running at twice the system rate. The divisor is never below two. Divider settings are accepted only while the pixel clock stage is off.

Top module: `disp_stage_seq`

## Requirements
- R1: After reset, the stage status `stageOn` is 000 and `pixClkEn` is low. Stage bit positions: bit 0 is pixel clock, bit 1 is sync, bit 2 is display.
- R2: A set command on bit 0 raises `stageOn[0]` in the cycle after the write. An accepted clear command on bit 0 lowers it in the cycle after the write. When set and clear arrive together, the clear wins.
- R3: An accepted set of sync or display holds its status bit low until a cycle with `frameEnd` high. The bit rises in the following cycle.
- R4: A sync set is refused while the pixel clock stage is inactive. A display set is refused while sync is inactive or has a clear pending, including a sync clear accepted in the same cycle. A refused request leaves its status bit low after later frame boundaries.
- R5: A clear of the pixel clock is refused while sync is active or pending on. A clear of sync is refused while display is active or pending on.
- R6: An accepted clear of sync or display keeps its status bit high until a cycle with `frameEnd` high. The bit falls in the following cycle.
- R7: At all times, display active implies sync active, and sync active implies pixel clock active.
- R8: With divisor N and the base source, `pixClkEn` is high on the Nth cycle in which the pixel clock stage is active, and every N cycles after that. It is never high while the stage is off.
- R9: With the doubled-rate select, and `srcDouble` reading 1, `pixClkEn` pulses every N/2 cycles for an even N.
- R10: A divisor value of 0 or 1 is treated as 2.
- R11: Divider writes (`cfgWr`) made while the pixel clock stage is active are ignored. The period and `srcDouble` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| setWr | input | 1 | Write strobe of the set command |
| setMask | input | 3 | Stages to start |
| clrWr | input | 1 | Write strobe of the clear command |
| clrMask | input | 3 | Stages to stop |
| frameEnd | input | 1 | Frame boundary pulse from the timing generator |
| cfgWr | input | 1 | Divider configuration write strobe |
| cfgDiv | input | DIV_W | Divisor value |
| cfgDouble | input | 1 | Select the doubled-rate source |
| stageOn | output | 3 | Per-stage status and stage enables |
| pixClkEn | output | 1 | Single-cycle pixel clock enable |
| srcDouble | output | 1 | Latched source select, to the clock mux |

## Verification
The hardest situation to reach is a pair of conflicting commands in one cycle. Examples are a display set that arrives with a sync clear, or a pixel clock clear racing a pending sync enable. In each case the refusal depends on state that has not yet reached the status bits.

The stimulus first brings the pipeline up through real frame boundaries. It then issues both writes on the same clock edge, before a boundary arrives. Divider writes are also made while the pixel clock runs. The bench then checks that the pulse phase continues without a break.

// File: rtl/disp_stage_pkg.sv
package disp_stage_pkg;
  localparam int NUM_STAGES = 3;
  localparam int STG_PCLK   = 0;
  localparam int STG_SYNC   = 1;
  localparam int STG_DISP   = 2;
  localparam int MIN_DIV    = 2;

  typedef struct packed {
    logic pclkRun;
    logic divLoad;
  } dpStrobe_t;
endpackage

// File: rtl/disp_stage_ctrl.sv
module disp_stage_ctrl
  import disp_stage_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  setWr,
  input  logic [NUM_STAGES-1:0] setMask,
  input  logic                  clrWr,
  input  logic [NUM_STAGES-1:0] clrMask,
  input  logic                  frameEnd,
  input  logic                  cfgWr,
  output logic [NUM_STAGES-1:0] stageOn,
  output dpStrobe_t             strobe
);
  logic [NUM_STAGES-1:0] setHit, clrHit;
  logic [NUM_STAGES-1:1] onPend, offPend, setAcc, clrAcc;
  logic pclkOff;

  assign setHit = {NUM_STAGES{setWr}} & setMask;
  assign clrHit = {NUM_STAGES{clrWr}} & clrMask;

  always_comb begin
    // a stage may stop only once nothing above it is running or coming up
    pclkOff = clrHit[STG_PCLK] & stageOn[STG_PCLK] & ~stageOn[STG_SYNC] & ~onPend[STG_SYNC];
    clrAcc[STG_SYNC] = clrHit[STG_SYNC] & stageOn[STG_SYNC] & ~offPend[STG_SYNC]
                     & ~stageOn[STG_DISP] & ~onPend[STG_DISP];
    clrAcc[STG_DISP] = clrHit[STG_DISP] & stageOn[STG_DISP] & ~offPend[STG_DISP];
    // a stage may start only on a stable, active stage below it
    setAcc[STG_SYNC] = setHit[STG_SYNC] & ~stageOn[STG_SYNC] & ~onPend[STG_SYNC]
                     & stageOn[STG_PCLK] & ~pclkOff;
    setAcc[STG_DISP] = setHit[STG_DISP] & ~stageOn[STG_DISP] & ~onPend[STG_DISP]
                     & stageOn[STG_SYNC] & ~offPend[STG_SYNC] & ~clrAcc[STG_SYNC];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageOn <= '0;
      onPend  <= '0;
      offPend <= '0;
    end else begin
      if (pclkOff)
        stageOn[STG_PCLK] <= 1'b0;
      else if (setHit[STG_PCLK] && !clrHit[STG_PCLK])
        stageOn[STG_PCLK] <= 1'b1;
      for (int k = 1; k < NUM_STAGES; k++) begin
        if (frameEnd) begin
          stageOn[k] <= onPend[k] | (stageOn[k] & ~offPend[k]);
          onPend[k]  <= setAcc[k];
          offPend[k] <= clrAcc[k];
        end else begin
          onPend[k]  <= onPend[k] | setAcc[k];
          offPend[k] <= offPend[k] | clrAcc[k];
        end
      end
    end
  end

  assign strobe.pclkRun = stageOn[STG_PCLK];
  assign strobe.divLoad = cfgWr & ~stageOn[STG_PCLK];
endmodule

// File: rtl/disp_pclk_div.sv
module disp_pclk_div
  import disp_stage_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgDouble,
  output logic             pixClkEn,
  output logic             srcDouble
);
  localparam int ACC_W = DIV_W + 1;

  logic [DIV_W-1:0] divisor;
  logic [ACC_W-1:0] acc, sum, step, divExt;
  logic             wrap;

  assign step   = srcDouble ? ACC_W'(2) : ACC_W'(1);
  assign divExt = {1'b0, divisor};
  assign sum    = acc + step;
  assign wrap   = sum >= divExt;
  assign pixClkEn = strobe.pclkRun & wrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisor   <= DIV_W'(MIN_DIV);
      srcDouble <= 1'b0;
      acc       <= '0;
    end else begin
      if (strobe.divLoad) begin
        divisor   <= (cfgDiv < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : cfgDiv;
        srcDouble <= cfgDouble;
      end
      if (!strobe.pclkRun) acc <= '0;
      else if (wrap)       acc <= sum - divExt;
      else                 acc <= sum;
    end
  end
endmodule

// File: rtl/disp_stage_seq.sv
module disp_stage_seq
  import disp_stage_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setWr,
  input  logic [2:0]       setMask,
  input  logic             clrWr,
  input  logic [2:0]       clrMask,
  input  logic             frameEnd,
  input  logic             cfgWr,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgDouble,
  output logic [2:0]       stageOn,
  output logic             pixClkEn,
  output logic             srcDouble
);
  dpStrobe_t strobe;

  disp_stage_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .setWr(setWr), .setMask(setMask),
    .clrWr(clrWr), .clrMask(clrMask), .frameEnd(frameEnd),
    .cfgWr(cfgWr), .stageOn(stageOn), .strobe(strobe)
  );

  disp_pclk_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgDiv(cfgDiv),
    .cfgDouble(cfgDouble), .pixClkEn(pixClkEn), .srcDouble(srcDouble)
  );
endmodule

// File: rtl/disp_stage_seq_chk.sv
module disp_stage_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       setWr,
  input logic [2:0] setMask,
  input logic       clrWr,
  input logic [2:0] clrMask,
  input logic       frameEnd,
  input logic [2:0] stageOn,
  input logic       pixClkEn,
  input logic       srcDouble
);
  AST_DISP_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    stageOn[2] |-> stageOn[1]); // R7
  AST_SYNC_NEEDS_PCLK: assert property (@(posedge clk) disable iff (!rstN)
    stageOn[1] |-> stageOn[0]); // R7
  AST_NO_PULSE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !stageOn[0] |-> !pixClkEn); // R8
  AST_FRAME_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(stageOn[2:1])); // R3
  AST_PCLK_START: assert property (@(posedge clk) disable iff (!rstN)
    (setWr && setMask[0] && !(clrWr && clrMask[0])) |=> stageOn[0]); // R2
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    stageOn[0] |=> $stable(srcDouble)); // R11
endmodule

bind disp_stage_seq disp_stage_seq_chk chk_i (.*);

// File: tb/disp_stage_seq_tb_top.sv
`timescale 1ns/1ps
module disp_stage_seq_tb_top;
  localparam int DIV_W = 8;
  localparam int K_STATUS = 0, K_PULSE = 1, K_DBL = 2;

  typedef struct {
    string tag;
    int    kind;
    int    exp;
  } item_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic setWr = 1'b0, clrWr = 1'b0, frameEnd = 1'b0, cfgWr = 1'b0, cfgDouble = 1'b0;
  logic [2:0] setMask = '0, clrMask = '0;
  logic [DIV_W-1:0] cfgDiv = '0;
  logic [2:0] stageOn;
  logic pixClkEn, srcDouble;

  item_t q[$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  disp_stage_seq #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .setWr(setWr), .setMask(setMask), .clrWr(clrWr),
    .clrMask(clrMask), .frameEnd(frameEnd), .cfgWr(cfgWr), .cfgDiv(cfgDiv),
    .cfgDouble(cfgDouble), .stageOn(stageOn), .pixClkEn(pixClkEn), .srcDouble(srcDouble)
  );

  task automatic push(string tag, int kind, int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doSet(logic [2:0] m);
    setWr = 1'b1; setMask = m; tick(); setWr = 1'b0; setMask = '0;
  endtask

  task automatic doClr(logic [2:0] m);
    clrWr = 1'b1; clrMask = m; tick(); clrWr = 1'b0; clrMask = '0;
  endtask

  task automatic frame();
    frameEnd = 1'b1; tick(); frameEnd = 1'b0;
  endtask

  task automatic setCfg(int d, logic dbl);
    cfgWr = 1'b1; cfgDiv = DIV_W'(d); cfgDouble = dbl; tick(); cfgWr = 1'b0;
  endtask

  task automatic checkPulses(string tag, int n, int period, int start);
    for (int i = 0; i < n; i++) begin
      push(tag, K_PULSE, ((start + i) % period == period - 1) ? 1 : 0);
      tick();
    end
  endtask

  // monitor: pops expectations and compares just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = (it.kind == K_STATUS) ? int'(stageOn) :
              (it.kind == K_PULSE) ? int'(pixClkEn) : int'(srcDouble);
        nChecks++;
        if (act != it.exp) begin
          nFails++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d at %0t", it.tag, it.kind, act, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push("R1", K_STATUS, 0);
    push("R1", K_PULSE, 0);
    tick();
    rstN = 1'b1;
    tick();

    // R4: sync without pixel clock is refused
    doSet(3'b010);
    frame();
    push("R4", K_STATUS, 3'b000);

    setCfg(4, 1'b0);
    push("R9", K_DBL, 0);

    // R2 + R8: pixel clock stage, divide by 4
    doSet(3'b001);
    push("R2", K_STATUS, 3'b001);
    checkPulses("R8", 8, 4, 0);

    // R11: divider write while running is ignored
    cfgWr = 1'b1; cfgDiv = 8'd6; cfgDouble = 1'b1;
    tick();
    cfgWr = 1'b0;
    push("R11", K_DBL, 0);
    checkPulses("R11", 8, 4, 1);

    // R3: sync waits for frame; display refused while sync not active (R4)
    doSet(3'b010);
    push("R3", K_STATUS, 3'b001);
    doSet(3'b100);
    frame();
    push("R3", K_STATUS, 3'b011);
    frame();
    push("R4", K_STATUS, 3'b011);

    // R5: pixel clock clear refused while sync active
    doClr(3'b001);
    push("R5", K_STATUS, 3'b011);

    doSet(3'b100);
    push("R3", K_STATUS, 3'b011);
    frame();
    push("R3", K_STATUS, 3'b111);

    // R5: sync clear refused while display active
    doClr(3'b010);
    frame();
    push("R5", K_STATUS, 3'b111);

    // R6: display clear lags until frame end
    doClr(3'b100);
    push("R6", K_STATUS, 3'b111);
    frame();
    push("R6", K_STATUS, 3'b011);

    // R6/R5: sync clear pending, pixel clock clear still refused
    doClr(3'b010);
    doClr(3'b001);
    push("R5", K_STATUS, 3'b011);
    frame();
    push("R6", K_STATUS, 3'b001);
    doClr(3'b001);
    push("R2", K_STATUS, 3'b000);
    checkPulses("R8", 4, 1000, 0);

    // R10: divisor 1 acts as 2
    setCfg(1, 1'b0);
    doSet(3'b001);
    checkPulses("R10", 6, 2, 0);
    doClr(3'b001);

    // R9: doubled source, divisor 6 -> every 3 cycles
    setCfg(6, 1'b1);
    push("R9", K_DBL, 1);
    doSet(3'b001);
    checkPulses("R9", 9, 3, 0);
    doClr(3'b001);

    // R10: divisor 0 with doubled source -> every cycle
    setCfg(0, 1'b1);
    doSet(3'b001);
    checkPulses("R10", 4, 1, 0);

    // R4: display set in the same cycle as an accepted sync clear
    doSet(3'b010);
    frame();
    push("R3", K_STATUS, 3'b011);
    setWr = 1'b1; setMask = 3'b100; clrWr = 1'b1; clrMask = 3'b010;
    tick();
    setWr = 1'b0; setMask = '0; clrWr = 1'b0; clrMask = '0;
    frame();
    push("R4", K_STATUS, 3'b001);

    tick(); tick();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule